// File: doc/BRIEF.md
# NAND Read-Cache Die State Tracker

This block follows the command and status behaviour of one NAND flash die while it serves plain page reads and pipelined cache reads. A host bus controller hands it one already decoded command byte per strobe, together with a page index and a column index for the commands that need them. The block drives a ready/busy line and two status bits. `st_rdy` says the cache register can be used. `st_ardy` says the array is idle as well.

Inside, the block tracks three things: the read in progress, the pending array-to-data-register copy, and the page that sits in the cache register. It also keeps an output column pointer. Busy times are counted in clock cycles set by parameters, so the timing is exact and can be predicted. A command that is not legal in the current phase gives a one-cycle `illegal` pulse and leaves the state as it was. The array contents and the data path are not modelled. Each page is an opaque index.

Top module: `nand_cache_lun`

## Requirements
- R1: After `rst_n` is released, `busy_n`, `st_rdy` and `st_ardy` are 1, `illegal` is 0 and `col_addr` is 0.
- R2: Code 0x00 followed by code 0x30 (page taken from `page_in` with the 0x30 strobe) holds `busy_n`, `st_rdy` and `st_ardy` at 0 for exactly T_R cycles. After that, all three are 1 and `cache_page` equals the page given.
- R3: Code 0x31 (sequential cache read) is legal once a page has been read. The die is fully busy for the remaining array-copy cycles plus T_CB. It then shows `st_rdy`=1 and `st_ardy`=0. `cache_page` takes the page held in the data register, and an array copy of the last requested page plus one starts and lasts T_R cycles.
- R4: Code 0x00 followed by code 0x31 (random cache read) behaves as R3, except that the array copies the page on `page_in` at the 0x31 strobe.
- R5: Code 0x3F, legal only in cache mode, is fully busy for the remaining array-copy cycles plus T_CB. It then shows `st_rdy`=1 and `st_ardy`=1, with `cache_page` equal to the last page copied.
- R6: `col_addr` becomes 0 whenever the cache register is loaded. Code 0x05 followed by code 0xE0 loads `col_addr` from `col_in` at the 0xE0 strobe.
- R7: While `st_rdy`=0, only codes 0x70, 0x78 and 0xFF are accepted. Every other code raises `illegal`.
- R8: While `st_rdy`=1 and `st_ardy`=0, the codes accepted are 0x70, 0x78, 0x00, 0x05, 0x31, 0x3F and 0xFF. Every other code raises `illegal` and leaves `st_rdy`=1 and `st_ardy`=0.
- R9: A rejected command gives a one-cycle `illegal` pulse in the cycle after its strobe and does not change the state. While a second command byte is awaited, only the matching second byte or 0xFF is accepted.
- R10: Code 0xFF is accepted in every state. It holds the die fully busy for exactly T_RST cycles and then returns it to idle with `st_rdy`=1 and `st_ardy`=1. Cache mode and the record of a valid page are both cleared.
- R11: Code 0x3F outside cache mode, and code 0x31 before any page has been read, are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per byte |
| cmd_code | input | 8 | Decoded command byte |
| page_in | input | PW | Page index, sampled with 0x30 and with the 0x31 of 0x00-0x31 |
| col_in | input | CW | Column index, sampled with 0xE0 |
| busy_n | output | 1 | Ready/busy line, high when ready |
| st_rdy | output | 1 | Status: cache register available |
| st_ardy | output | 1 | Status: array idle as well |
| illegal | output | 1 | One-cycle pulse for a rejected command |
| cache_page | output | PW | Page index held in the cache register |
| col_addr | output | CW | Current output column |

## Verification
The bench targets these corner cases:

- **Back-to-back 0x31.** The second fully busy phase must include the array-copy cycles still outstanding. A design that ignored them would report ready too early, and the data-register page would be overwritten.
- **Page order through the pipeline.** Sequential and random cache reads are checked for the page that reaches the cache register. A design that copied the requested page straight to the cache would show a page one step ahead of the expected one.
- **Codes rejected in each phase.** All byte values are swept while the die is fully busy, and again while only the array is busy. A design with a wrong accept set would raise `illegal` for a status read, or stay silent for a stray byte.
- **Reset in mid-operation.** 0xFF is issued during a busy phase. A reset that did not clear cache mode would then accept 0x3F.

// File: rtl/nand_cache_lun.sv
module nand_cache_lun #(
  parameter int PW    = 8,
  parameter int CW    = 12,
  parameter int T_R   = 12,
  parameter int T_CB  = 3,
  parameter int T_RST = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_code,
  input  logic [PW-1:0] page_in,
  input  logic [CW-1:0] col_in,
  output logic          busy_n,
  output logic          st_rdy,
  output logic          st_ardy,
  output logic          illegal,
  output logic [PW-1:0] cache_page,
  output logic [CW-1:0] col_addr
);
  localparam int TMAX = (T_R > T_RST ? (T_R > T_CB ? T_R : T_CB) : (T_RST > T_CB ? T_RST : T_CB));
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_READY, S_PEND_RD, S_PEND_COL, S_ARRAY, S_CBUSY, S_LBUSY, S_RST} st_t;

  st_t st;
  logic cmode, have_pg, legal, ph_done;
  logic [TW-1:0] cnt, arr;
  logic [PW-1:0] tgt, data_pg, last_pg;

  wire is_stat  = cmd_code == 8'h70 || cmd_code == 8'h78;
  wire is_rst   = cmd_code == 8'hFF;
  wire arr_idle = arr == '0;
  wire go       = cmd_valid && legal;

  assign st_rdy  = st == S_READY || st == S_PEND_RD || st == S_PEND_COL;
  assign st_ardy = st_rdy && !cmode;
  assign busy_n  = st_rdy;

  always_comb begin
    case (st)
      S_READY:    legal = is_stat || is_rst || cmd_code == 8'h00 || cmd_code == 8'h05 ||
                          (cmd_code == 8'h31 && have_pg) || (cmd_code == 8'h3F && cmode);
      S_PEND_RD:  legal = is_rst || (cmd_code == 8'h30 && !cmode) || (cmd_code == 8'h31 && have_pg);
      S_PEND_COL: legal = is_rst || cmd_code == 8'hE0;
      default:    legal = is_stat || is_rst;
    endcase
    case (st)
      S_ARRAY:          ph_done = cnt == TW'(T_R - 1);
      S_CBUSY, S_LBUSY: ph_done = arr_idle && cnt == TW'(T_CB - 1);
      S_RST:            ph_done = cnt == TW'(T_RST - 1);
      default:          ph_done = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_READY; cmode <= 1'b0; have_pg <= 1'b0; illegal <= 1'b0;
      cnt <= '0; arr <= '0; tgt <= '0; data_pg <= '0; last_pg <= '0;
      cache_page <= '0; col_addr <= '0;
    end else begin
      illegal <= cmd_valid && !legal;
      if (!arr_idle) arr <= arr - 1'b1;
      if (st == S_ARRAY || st == S_RST || ((st == S_CBUSY || st == S_LBUSY) && arr_idle))
        cnt <= cnt + 1'b1;
      if (go && is_rst) begin
        st <= S_RST; cnt <= '0; arr <= '0;
        cmode <= 1'b0; have_pg <= 1'b0; col_addr <= '0;
      end else if (ph_done) begin
        st <= S_READY;
        col_addr <= '0;
        case (st)
          S_ARRAY: begin
            cache_page <= tgt; data_pg <= tgt; last_pg <= tgt; have_pg <= 1'b1;
          end
          S_CBUSY: begin
            cache_page <= data_pg; data_pg <= tgt; last_pg <= tgt;
            arr <= TW'(T_R); cmode <= 1'b1;
          end
          S_LBUSY: begin
            cache_page <= data_pg; cmode <= 1'b0;
          end
          default: ;
        endcase
      end else if (go) begin
        case (st)
          S_READY: begin
            if (cmd_code == 8'h00) st <= S_PEND_RD;
            if (cmd_code == 8'h05) st <= S_PEND_COL;
            if (cmd_code == 8'h31) begin st <= S_CBUSY; cnt <= '0; tgt <= last_pg + 1'b1; end
            if (cmd_code == 8'h3F) begin st <= S_LBUSY; cnt <= '0; end
          end
          S_PEND_RD: begin
            tgt <= page_in; cnt <= '0;
            st  <= (cmd_code == 8'h30) ? S_ARRAY : S_CBUSY;
          end
          S_PEND_COL: begin
            col_addr <= col_in; st <= S_READY;
          end
          default: ;
        endcase
      end
    end
  end

  p_busy_only_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !st_rdy && !is_stat && !is_rst) |=> illegal);

  p_reject_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !legal && st_rdy) |=> (st == $past(st) && $stable(cmode)));

  p_ready_col_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_rdy) |-> col_addr == '0);

  p_cache_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_CBUSY && st == S_READY) |-> (busy_n && !st_ardy && !arr_idle));

  p_last_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_LBUSY && st == S_READY) |-> (st_ardy && cache_page == $past(data_pg)));

  p_reset_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RST) |-> (cnt < TW'(T_RST) && arr_idle));
endmodule

// File: tb/nand_cache_lun_tb.sv
module nand_cache_lun_tb;
  localparam int PW = 8, CW = 12, T_R = 12, T_CB = 3, T_RST = 5;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic [PW-1:0] page_in = '0;
  logic [CW-1:0] col_in = '0;
  logic busy_n, st_rdy, st_ardy, illegal;
  logic [PW-1:0] cache_page;
  logic [CW-1:0] col_addr;
  int total = 0, bad = 0, n = 0;

  always #2 clk = ~clk;

  nand_cache_lun #(.PW(PW), .CW(CW), .T_R(T_R), .T_CB(T_CB), .T_RST(T_RST)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .page_in(page_in), .col_in(col_in), .busy_n(busy_n), .st_rdy(st_rdy),
    .st_ardy(st_ardy), .illegal(illegal), .cache_page(cache_page), .col_addr(col_addr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c, input int pg = 0, input int cl = 0);
    cmd_valid = 1'b1; cmd_code = c; page_in = PW'(pg); col_in = CW'(cl);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    while (!busy_n) begin cyc++; @(negedge clk); end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_n && st_rdy && st_ardy && !illegal, "R1 ready flags", {busy_n, st_rdy, st_ardy, illegal}, 4'b1110);
    chk(col_addr == 0, "R1 column", col_addr, 0);

    send(8'h3F);
    chk(illegal && st_ardy, "R11 3F outside cache", {illegal, st_ardy}, 2'b11);
    send(8'h31);
    chk(illegal && st_ardy, "R11 31 without page", {illegal, st_ardy}, 2'b11);

    for (int p = 0; p < 8; p++) begin
      send(8'h00);
      send(8'h30, (p * 37 + 3) % 256);
      chk(!st_rdy && !st_ardy, "R2 fully busy", {st_rdy, st_ardy}, 0);
      wait_ready(n);
      chk(n == T_R, "R2 busy length", n, T_R);
      chk(cache_page == (p * 37 + 3) % 256 && st_ardy, "R2 page loaded", cache_page, (p * 37 + 3) % 256);
    end

    send(8'h00); send(8'h30, 5); wait_ready(n);
    send(8'h05); send(8'hE0, 0, 7);
    chk(col_addr == 7, "R6 column set", col_addr, 7);

    send(8'h31); wait_ready(n);
    chk(n == T_CB, "R3 cache busy", n, T_CB);
    chk(st_rdy && !st_ardy, "R3 array busy", {st_rdy, st_ardy}, 2'b10);
    chk(cache_page == 5, "R3 cache page", cache_page, 5);
    chk(col_addr == 0, "R6 column cleared", col_addr, 0);

    send(8'h30);
    chk(illegal && st_rdy && !st_ardy, "R9 rejected held", {illegal, st_rdy, st_ardy}, 3'b110);
    send(8'h70);
    chk(!illegal, "R8 status accepted", illegal, 0);

    idle(20);
    send(8'h31); wait_ready(n);
    chk(n == T_CB && cache_page == 6, "R3 sequential next", cache_page, 6);
    send(8'h31); wait_ready(n);
    chk(n == T_R - 1 + T_CB, "R3 back-to-back busy", n, T_R - 1 + T_CB);
    chk(cache_page == 7, "R3 back-to-back page", cache_page, 7);

    send(8'h05); send(8'hE0, 0, 100);
    chk(col_addr == 100 && !st_ardy, "R8 column in cache mode", col_addr, 100);

    idle(20);
    send(8'h00); send(8'h31, 40); wait_ready(n);
    chk(n == T_CB && cache_page == 8 && !st_ardy, "R4 random cache", cache_page, 8);

    for (int c = 0; c < 256; c++) begin
      if (c == 8'h70 || c == 8'h78 || c == 8'h00 || c == 8'h05 || c == 8'h31 ||
          c == 8'h3F || c == 8'hFF) continue;
      send(8'(c));
      chk(illegal && st_rdy && !st_ardy, "R8 reject in cache mode", c, -1);
    end

    idle(20);
    send(8'h3F); wait_ready(n);
    chk(n == T_CB, "R5 last busy", n, T_CB);
    chk(st_rdy && st_ardy && cache_page == 40, "R5 last page", cache_page, 40);

    for (int c = 0; c < 255; c++) begin
      send(8'h00); send(8'h30, 1);
      send(8'(c));
      chk(illegal == !(c == 8'h70 || c == 8'h78), "R7 busy accept set", illegal, !(c == 8'h70 || c == 8'h78));
      wait_ready(n);
    end
    chk(cache_page == 1, "R7 busy unaffected", cache_page, 1);

    send(8'h00);
    send(8'h70);
    chk(illegal && st_rdy, "R9 pending rejects status", illegal, 1);
    send(8'h30, 9); wait_ready(n);
    chk(n == T_R && cache_page == 9, "R9 pending kept", cache_page, 9);

    send(8'h31); wait_ready(n);
    send(8'h31);
    send(8'hFF);
    wait_ready(n);
    chk(n == T_RST, "R10 reset length", n, T_RST);
    chk(st_rdy && st_ardy, "R10 idle after reset", {st_rdy, st_ardy}, 2'b11);
    send(8'h3F);
    chk(illegal, "R10 cache mode cleared", illegal, 1);
    send(8'h31);
    chk(illegal, "R11 page record cleared", illegal, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule